// File: doc/BRIEF.md
# Planar Display Sample Buffer Refill Controller

This block sits between a DMA engine and a video output formatter. It holds three separate sample stores, one for luma (Y) and one each for the two chroma planes (Cb, Cr). The luma store is twice as deep as each chroma store. The DMA engine fills each store through its own write-only port. The formatter takes samples out in groups of two luma, one Cb and one Cr, which is one pair of pixels in 4:2:2 order.

The controller keeps each store stocked by raising a one-cycle request toward the DMA engine when that store runs low. Software programs two values. The first is a pixel threshold, which is always even; chroma stores compare against half of it, so a luma burst is twice the size of a chroma burst. The second is a count of remaining luma requests. When that count reaches zero, all requests stop, so the DMA engine is only asked for data while more transfers are expected. A synchronous flush empties every store and re-arms the requests.

Top module: `planar_refill_ctrl`

## Requirements
- R1: After synchronous reset, y_req, cb_req, cr_req, rd_valid and ovf_flags are all 0, the threshold is 0 and the request count is 0.
- R2: The luma store holds Y_DEPTH samples and each chroma store holds Y_DEPTH/2. A write to a full store is dropped and sets that store's sticky bit in ovf_flags (bit 0 luma, bit 1 Cb, bit 2 Cr). Only reset clears these bits.
- R3: A threshold write stores the value with bit 0 forced to 0. The luma store counts as low when its fill level is below the threshold. Each chroma store counts as low when its fill level is below half the threshold.
- R4: A request is raised in a cycle where its store is low, no request for that store is outstanding, the request count is nonzero and flush is 0. In that case the matching *_req output is 1 for exactly the following cycle.
- R5: After a request, that store issues no further request until its fill level is no longer low. Once it is no longer low, it may request again.
- R6: cfg_cnt_we loads the request count, and a load takes precedence over a decrement. Each luma request decrements the count by one; chroma requests leave it unchanged. While the count is 0, none of the three requests is raised.
- R7: An rd_en is accepted when the luma store holds at least 2 samples and each chroma store at least 1. On the following cycle rd_valid is 1 and rd_y0, rd_y1, rd_cb and rd_cr carry the oldest samples in write order; rd_y0 is the older luma sample. Otherwise rd_en is ignored: nothing is consumed and rd_valid is 0.
- R8: flush empties all three stores and clears the outstanding-request state, so a store that is still low requests again. Writes in the flush cycle are dropped, and flush leaves ovf_flags unchanged.
- R9: A write and an accepted read on the same store in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty all stores, re-arm requests |
| cfg_thr_we | input | 1 | Load pixel threshold |
| cfg_thr_val | input | YLW | Threshold value (bit 0 ignored) |
| cfg_cnt_we | input | 1 | Load remaining request count |
| cfg_cnt_val | input | EVC_W | Request count value |
| y_wr_en | input | 1 | Luma write strobe |
| y_wr_data | input | DW | Luma sample |
| cb_wr_en | input | 1 | Cb write strobe |
| cb_wr_data | input | DW | Cb sample |
| cr_wr_en | input | 1 | Cr write strobe |
| cr_wr_data | input | DW | Cr sample |
| rd_en | input | 1 | Request one pixel pair |
| rd_valid | output | 1 | Read data valid |
| rd_y0 | output | DW | Older luma sample |
| rd_y1 | output | DW | Newer luma sample |
| rd_cb | output | DW | Cb sample |
| rd_cr | output | DW | Cr sample |
| y_req | output | 1 | Luma refill request pulse |
| cb_req | output | 1 | Cb refill request pulse |
| cr_req | output | 1 | Cr refill request pulse |
| ovf_flags | output | 3 | Sticky dropped-write flags |

## Verification
Several properties are checked on every cycle by assertions:
- luma requests are single-cycle pulses;
- each one is preceded by a low luma level and a nonzero count, which then drops by exactly one;
- the stored threshold stays even;
- overflow flags set on a full write and stay set;
- flush empties the luma store;
- rd_valid only follows an rd_en.

Other behaviours need the bench's cycle model to show them:
- the exact cycle and number of chroma requests;
- re-arming after a refill or a flush;
- the order of the data in a pair;
- writes dropped during flush;
- concurrent write and read on the same store.

// File: rtl/planar_pkg.sv
package planar_pkg;
  localparam int NPLANE = 3;
  localparam int PL_Y   = 0;
  localparam int PL_CB  = 1;
  localparam int PL_CR  = 2;
endpackage

// File: rtl/planar_sample_fifo.sv
module planar_sample_fifo #(
  parameter  int DW    = 8,
  parameter  int DEPTH = 16,
  parameter  int LANES = 1,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                wr_en,
  input  logic [DW-1:0]       wr_data,
  input  logic                pop,
  output logic [LANES*DW-1:0] rd_data,
  output logic [LW-1:0]       level,
  output logic                ovf
);
  localparam int BANK_D = DEPTH / LANES;
  localparam int AW     = $clog2(BANK_D);
  localparam int SELW   = (LANES > 1) ? $clog2(LANES) : 1;

  logic [SELW-1:0] wsel;
  logic [AW-1:0]   waddr, raddr;
  logic            full, accept;

  assign full   = (level == LW'(DEPTH));
  assign accept = wr_en && !flush && !full;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wsel  <= '0;
      waddr <= '0;
      raddr <= '0;
      level <= '0;
    end else begin
      if (accept) begin
        if (wsel == SELW'(LANES - 1)) begin
          wsel  <= '0;
          waddr <= (waddr == AW'(BANK_D - 1)) ? '0 : waddr + AW'(1);
        end else begin
          wsel <= wsel + SELW'(1);
        end
      end
      if (pop)
        raddr <= (raddr == AW'(BANK_D - 1)) ? '0 : raddr + AW'(1);
      level <= level + LW'(accept) - (pop ? LW'(LANES) : LW'(0));
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ovf <= 1'b0;
    else if (wr_en && !flush && full)
      ovf <= 1'b1;
  end

  // One bank per read lane; consecutive writes rotate across banks.
  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [DW-1:0] mem [BANK_D];
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (accept && (wsel == SELW'(b)))
        mem[waddr] <= wr_data;
      if (pop)
        q <= mem[raddr];
    end
    assign rd_data[b*DW +: DW] = q;
  end
endmodule

// File: rtl/planar_refill_gate.sv
module planar_refill_gate #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] thresh,
  input  logic          enable,
  output logic          fire,
  output logic          req
);
  logic pend;
  logic low;

  assign low  = (level < thresh);
  assign fire = low && !pend && enable && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      req  <= 1'b0;
    end else begin
      req <= fire;
      if (flush)
        pend <= 1'b0;
      else if (fire)
        pend <= 1'b1;
      else if (!low)
        pend <= 1'b0;
    end
  end
endmodule

// File: rtl/planar_refill_ctrl.sv
module planar_refill_ctrl
  import planar_pkg::*;
#(
  parameter  int DW      = 8,
  parameter  int Y_DEPTH = 2560,
  parameter  int EVC_W   = 16,
  localparam int C_DEPTH = Y_DEPTH / 2,
  localparam int YLW     = $clog2(Y_DEPTH + 1),
  localparam int CLW     = $clog2(C_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             cfg_thr_we,
  input  logic [YLW-1:0]   cfg_thr_val,
  input  logic             cfg_cnt_we,
  input  logic [EVC_W-1:0] cfg_cnt_val,
  input  logic             y_wr_en,
  input  logic [DW-1:0]    y_wr_data,
  input  logic             cb_wr_en,
  input  logic [DW-1:0]    cb_wr_data,
  input  logic             cr_wr_en,
  input  logic [DW-1:0]    cr_wr_data,
  input  logic             rd_en,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_y0,
  output logic [DW-1:0]    rd_y1,
  output logic [DW-1:0]    rd_cb,
  output logic [DW-1:0]    rd_cr,
  output logic             y_req,
  output logic             cb_req,
  output logic             cr_req,
  output logic [2:0]       ovf_flags
);
  logic [YLW-1:0]   thr_q;
  logic [EVC_W-1:0] evc_q;
  logic [YLW-1:0]   y_level;
  logic [CLW-1:0]   cb_level, cr_level;
  logic [2*DW-1:0]  y_rd;
  logic             pop;
  logic [NPLANE-1:0] fire, req, ovf_bits;
  logic [YLW-1:0]   lvl    [NPLANE];
  logic [YLW-1:0]   thr_pl [NPLANE];

  // Configuration: threshold kept even, request count loads or counts down.
  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= '0;
      evc_q <= '0;
    end else begin
      if (cfg_thr_we)
        thr_q <= cfg_thr_val & {{(YLW-1){1'b1}}, 1'b0};
      if (cfg_cnt_we)
        evc_q <= cfg_cnt_val;
      else if (fire[PL_Y])
        evc_q <= evc_q - EVC_W'(1);
    end
  end

  assign pop = rd_en && !flush && (y_level >= YLW'(2)) &&
               (cb_level != '0) && (cr_level != '0);

  always_ff @(posedge clk) begin
    if (rst)
      rd_valid <= 1'b0;
    else
      rd_valid <= pop;
  end

  planar_sample_fifo #(.DW(DW), .DEPTH(Y_DEPTH), .LANES(2)) u_y_fifo (
    .clk, .rst, .flush, .wr_en(y_wr_en), .wr_data(y_wr_data), .pop,
    .rd_data(y_rd), .level(y_level), .ovf(ovf_bits[PL_Y]));

  planar_sample_fifo #(.DW(DW), .DEPTH(C_DEPTH), .LANES(1)) u_cb_fifo (
    .clk, .rst, .flush, .wr_en(cb_wr_en), .wr_data(cb_wr_data), .pop,
    .rd_data(rd_cb), .level(cb_level), .ovf(ovf_bits[PL_CB]));

  planar_sample_fifo #(.DW(DW), .DEPTH(C_DEPTH), .LANES(1)) u_cr_fifo (
    .clk, .rst, .flush, .wr_en(cr_wr_en), .wr_data(cr_wr_data), .pop,
    .rd_data(rd_cr), .level(cr_level), .ovf(ovf_bits[PL_CR]));

  assign rd_y0 = y_rd[DW-1:0];
  assign rd_y1 = y_rd[2*DW-1:DW];

  assign lvl[PL_Y]     = y_level;
  assign lvl[PL_CB]    = YLW'(cb_level);
  assign lvl[PL_CR]    = YLW'(cr_level);
  assign thr_pl[PL_Y]  = thr_q;
  assign thr_pl[PL_CB] = thr_q >> 1;
  assign thr_pl[PL_CR] = thr_q >> 1;

  for (genvar p = 0; p < NPLANE; p++) begin : g_gate
    planar_refill_gate #(.LW(YLW)) u_gate (
      .clk, .rst, .flush, .level(lvl[p]), .thresh(thr_pl[p]),
      .enable(evc_q != '0), .fire(fire[p]), .req(req[p]));
  end

  assign y_req     = req[PL_Y];
  assign cb_req    = req[PL_CB];
  assign cr_req    = req[PL_CR];
  assign ovf_flags = ovf_bits;
endmodule

// File: rtl/planar_refill_ctrl_chk.sv
module planar_refill_ctrl_chk #(
  parameter int YLW     = 12,
  parameter int EVC_W   = 16,
  parameter int Y_DEPTH = 2560
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             y_req,
  input logic             rd_en,
  input logic             rd_valid,
  input logic             cfg_cnt_we,
  input logic             y_wr_en,
  input logic [EVC_W-1:0] evc,
  input logic [YLW-1:0]   thr,
  input logic [YLW-1:0]   y_level,
  input logic [2:0]       ovf_flags
);
  p_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    y_req |=> !y_req);

  p_count_gate_r6: assert property (@(posedge clk) disable iff (rst)
    y_req |-> ($past(evc) != '0));

  p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
    (y_req && !$past(cfg_cnt_we)) |-> (evc == $past(evc) - EVC_W'(1)));

  p_thr_even_r3: assert property (@(posedge clk) disable iff (rst)
    !thr[0]);

  p_req_low_r3: assert property (@(posedge clk) disable iff (rst)
    y_req |-> ($past(y_level) < $past(thr)));

  p_ovf_set_r2: assert property (@(posedge clk) disable iff (rst)
    (y_wr_en && !flush && (y_level == YLW'(Y_DEPTH))) |=> ovf_flags[0]);

  p_ovf_keep_r2: assert property (@(posedge clk) disable iff (rst)
    ovf_flags[0] |=> ovf_flags[0]);

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (y_level == '0));

  p_rd_valid_r7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));
endmodule

bind planar_refill_ctrl planar_refill_ctrl_chk #(
  .YLW(YLW), .EVC_W(EVC_W), .Y_DEPTH(Y_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .y_req(y_req), .rd_en(rd_en),
  .rd_valid(rd_valid), .cfg_cnt_we(cfg_cnt_we), .y_wr_en(y_wr_en),
  .evc(evc_q), .thr(thr_q), .y_level(y_level), .ovf_flags(ovf_flags));

// File: tb/planar_refill_ctrl_test.sv
module planar_refill_ctrl_test;
  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int YD    = 32;
  localparam int CD    = YD / 2;
  localparam int EW    = 16;
  localparam int YLW   = $clog2(YD + 1);

  logic clk = 0;
  logic rst = 1;
  logic flush = 0, cfg_thr_we = 0, cfg_cnt_we = 0, rd_en = 0;
  logic [YLW-1:0] cfg_thr_val = '0;
  logic [EW-1:0]  cfg_cnt_val = '0;
  logic y_wr_en = 0, cb_wr_en = 0, cr_wr_en = 0;
  logic [DW-1:0] y_wr_data = '0, cb_wr_data = '0, cr_wr_data = '0;
  logic rd_valid, y_req, cb_req, cr_req;
  logic [DW-1:0] rd_y0, rd_y1, rd_cb, rd_cr;
  logic [2:0] ovf_flags;

  planar_refill_ctrl #(.DW(DW), .Y_DEPTH(YD), .EVC_W(EW)) uut (
    .clk, .rst, .flush, .cfg_thr_we, .cfg_thr_val, .cfg_cnt_we, .cfg_cnt_val,
    .y_wr_en, .y_wr_data, .cb_wr_en, .cb_wr_data, .cr_wr_en, .cr_wr_data,
    .rd_en, .rd_valid, .rd_y0, .rd_y1, .rd_cb, .rd_cr,
    .y_req, .cb_req, .cr_req, .ovf_flags);

  always #(CLK_P/2) clk = ~clk;

  // Reference model, built from the requirements.
  logic [DW-1:0] yq[$], cbq[$], crq[$];
  int  m_thr, m_evc;
  bit  m_pend[3], m_ovf[3], e_req[3];
  bit  e_rdv;
  logic [DW-1:0] e_y0, e_y1, e_cb, e_cr;

  always @(posedge clk) begin
    int  lv[3], th[3];
    bit  f[3], low, fy, fcb, fcr, pp;
    if (rst) begin
      yq.delete(); cbq.delete(); crq.delete();
      m_thr = 0; m_evc = 0; e_rdv = 0;
      for (int p = 0; p < 3; p++) begin m_pend[p] = 0; m_ovf[p] = 0; e_req[p] = 0; end
    end else begin
      lv[0] = yq.size(); lv[1] = cbq.size(); lv[2] = crq.size();
      th[0] = m_thr; th[1] = m_thr / 2; th[2] = m_thr / 2;
      for (int p = 0; p < 3; p++) begin
        low = lv[p] < th[p];
        f[p] = low && !m_pend[p] && (m_evc != 0) && !flush;
        if (flush) m_pend[p] = 0;
        else if (f[p]) m_pend[p] = 1;
        else if (!low) m_pend[p] = 0;
        e_req[p] = f[p];
      end
      if (cfg_cnt_we) m_evc = int'(cfg_cnt_val);
      else if (f[0]) m_evc = m_evc - 1;
      if (cfg_thr_we) m_thr = int'(cfg_thr_val) & ~1;
      fy = (lv[0] == YD); fcb = (lv[1] == CD); fcr = (lv[2] == CD);
      pp = rd_en && lv[0] >= 2 && lv[1] >= 1 && lv[2] >= 1 && !flush;
      e_rdv = pp;
      if (pp) begin
        e_y0 = yq.pop_front(); e_y1 = yq.pop_front();
        e_cb = cbq.pop_front(); e_cr = crq.pop_front();
      end
      if (flush) begin
        yq.delete(); cbq.delete(); crq.delete();
      end else begin
        if (y_wr_en)  begin if (fy)  m_ovf[0] = 1; else yq.push_back(y_wr_data);  end
        if (cb_wr_en) begin if (fcb) m_ovf[1] = 1; else cbq.push_back(cb_wr_data); end
        if (cr_wr_en) begin if (fcr) m_ovf[2] = 1; else crq.push_back(cr_wr_data); end
      end
    end
  end

  int total = 0, fails = 0;
  int ny = 0, ncb = 0, ncr = 0;
  bit done = 0;
  string phase = "R1 reset";

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s]: got %0d expected %0d", tag, phase, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(y_req  === e_req[0], "R4 y_req",  int'(y_req),  int'(e_req[0]));
    chk(cb_req === e_req[1], "R4 cb_req", int'(cb_req), int'(e_req[1]));
    chk(cr_req === e_req[2], "R4 cr_req", int'(cr_req), int'(e_req[2]));
    chk(rd_valid === e_rdv, "R7 rd_valid", int'(rd_valid), int'(e_rdv));
    chk(ovf_flags === {m_ovf[2], m_ovf[1], m_ovf[0]}, "R2 ovf_flags",
        int'(ovf_flags), int'({m_ovf[2], m_ovf[1], m_ovf[0]}));
    if (e_rdv) begin
      chk(rd_y0 === e_y0, "R7 rd_y0", int'(rd_y0), int'(e_y0));
      chk(rd_y1 === e_y1, "R7 rd_y1", int'(rd_y1), int'(e_y1));
      chk(rd_cb === e_cb, "R7 rd_cb", int'(rd_cb), int'(e_cb));
      chk(rd_cr === e_cr, "R7 rd_cr", int'(rd_cr), int'(e_cr));
    end
    ny += int'(y_req); ncb += int'(cb_req); ncr += int'(cr_req);
  endtask

  task automatic idle();
    flush = 0; cfg_thr_we = 0; cfg_cnt_we = 0; rd_en = 0;
    y_wr_en = 0; cb_wr_en = 0; cr_wr_en = 0;
  endtask

  task automatic zero_counts();
    ny = 0; ncb = 0; ncr = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) step();
    rst = 0;
    step();
    chk(y_req == 0 && cb_req == 0 && cr_req == 0, "R1 no requests", int'(y_req), 0);
    chk(rd_valid == 0 && ovf_flags == 0, "R1 read/ovf idle", int'(ovf_flags), 0);

    // R3: an odd threshold 5 acts as 4; Y=4, Cb=Cr=2 are not low.
    phase = "R3 even threshold";
    cfg_thr_we = 1; cfg_thr_val = YLW'(5); step(); idle();
    for (int i = 0; i < 4; i++) begin
      y_wr_en = 1; y_wr_data = DW'(8'h10 + i);
      cb_wr_en = (i < 2); cb_wr_data = DW'(8'h40 + i);
      cr_wr_en = (i < 2); cr_wr_data = DW'(8'h80 + i);
      step();
    end
    idle();
    cfg_cnt_we = 1; cfg_cnt_val = EW'(8); step(); idle();
    zero_counts();
    repeat (6) step();
    chk(ny == 0 && ncb == 0 && ncr == 0, "R3 no request at threshold", ny + ncb + ncr, 0);

    // R7 / R5: one pair drains each store below its threshold: one request each.
    phase = "R7 pair read";
    zero_counts();
    rd_en = 1; step(); idle();
    chk(rd_y0 == 8'h10 && rd_y1 == 8'h11, "R7 luma order", int'(rd_y0), 'h10);
    phase = "R5 no reissue";
    repeat (8) step();
    chk(ny == 1, "R5 single luma request", ny, 1);
    chk(ncb == 1 && ncr == 1, "R5 single chroma request", ncb + ncr, 2);
    for (int i = 0; i < 2; i++) begin
      y_wr_en = 1; y_wr_data = DW'(8'h20 + i); step();
    end
    idle();
    rd_en = 1; step(); idle();
    repeat (4) step();
    chk(ny == 2, "R5 re-armed after refill", ny, 2);

    // R6: the count limits luma requests; flush re-arms stores that are still low.
    phase = "R6 count";
    cfg_cnt_we = 1; cfg_cnt_val = EW'(2); step(); idle();
    zero_counts();
    for (int k = 0; k < 4; k++) begin
      flush = 1; step(); idle();
      repeat (3) step();
    end
    chk(ny == 2, "R6 luma stops at zero", ny, 2);
    chk(ncb == 2 && ncr == 2, "R6 chroma blocked at zero", ncb + ncr, 4);

    // R2: one write beyond the luma depth.
    phase = "R2 overflow";
    flush = 1; step(); idle();
    for (int i = 0; i < YD + 1; i++) begin
      y_wr_en = 1; y_wr_data = DW'(i); step();
    end
    idle();
    chk(ovf_flags == 3'b001, "R2 luma overflow flag", int'(ovf_flags), 1);

    // R8: flush drops same-cycle writes and leaves flags set.
    phase = "R8 flush";
    flush = 1; y_wr_en = 1; y_wr_data = 8'hAA;
    cb_wr_en = 1; cb_wr_data = 8'hAB; cr_wr_en = 1; cr_wr_data = 8'hAC;
    step(); idle();
    chk(ovf_flags == 3'b001, "R8 flags survive flush", int'(ovf_flags), 1);
    rd_en = 1; step(); idle();
    chk(rd_valid == 0, "R8 empty after flush", int'(rd_valid), 0);
    y_wr_en = 1; y_wr_data = 8'h01; cb_wr_en = 1; cb_wr_data = 8'h03;
    cr_wr_en = 1; cr_wr_data = 8'h04; step(); idle();
    y_wr_en = 1; y_wr_data = 8'h02; step(); idle();
    rd_en = 1; step(); idle();
    chk(rd_valid == 1 && rd_y0 == 8'h01, "R8 flush-cycle write dropped", int'(rd_y0), 1);

    // R9 and everything else: random traffic against the model.
    phase = "R9 random";
    for (int n = 0; n < 3000; n++) begin
      y_wr_en  = ($urandom_range(0, 99) < 55); y_wr_data  = DW'($urandom);
      cb_wr_en = ($urandom_range(0, 99) < 30); cb_wr_data = DW'($urandom);
      cr_wr_en = ($urandom_range(0, 99) < 30); cr_wr_data = DW'($urandom);
      rd_en    = ($urandom_range(0, 99) < 40);
      flush    = ($urandom_range(0, 199) == 0);
      cfg_thr_we = ($urandom_range(0, 49) == 0); cfg_thr_val = YLW'($urandom_range(0, 63));
      cfg_cnt_we = ($urandom_range(0, 49) == 0); cfg_cnt_val = EW'($urandom_range(0, 20));
      step();
    end
    idle();
    repeat (2) step();

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog [%s]: got timeout expected completion", phase);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule